// File: doc/BRIEF.md
# DAC Interface Clock Source Autoconfiguration

This control block picks the clock source for a DAC interface and sets the default power state of the secondary DAC channels. It watches the routing setting of each DAC channel, a manual override enable, a manual clock-select field and a flag that shows the S/PDIF receiver is in use. From these it produces a registered 2-bit clock-select code. The code picks the master clock, the PLL A output or the PLL B output. The block also produces one power-down flag per DAC channel and two error flags for selections that are not allowed.

With no override, the routing decides everything. When DAC channel 1 takes its data from the S/PDIF receiver, the block selects PLL A and powers down every other DAC channel. For any other routing of channel 1 it selects the master clock and keeps all channels powered. When the override is enabled, the manual field decides the clock and no channel is powered down automatically. Some manual codes are not allowed: the reserved code, and either PLL while the S/PDIF receiver is in use. For these the block falls back to the master clock and raises a flag. The block does not switch clock waveforms; a downstream clock multiplexer acts on its select code.

Top module: `dac_clksrc_autocfg`

## Requirements
- R1: While rst_n is low at a rising clock edge, the next outputs are clk_sel_o = 2'b00, pwr_dn_o all zero, sel_invalid_o = 0 and sel_reserved_o = 0.
- R2: With ovr_en_i = 0 and DAC channel 1 routed to the parallel receiver (route code 2'b00), the serial receiver (2'b01) or code 2'b11 (handled as the parallel receiver), clk_sel_o is 2'b00 (master clock) and pwr_dn_o is all zero.
- R3: With ovr_en_i = 0 and DAC channel 1 routed to the S/PDIF receiver (route code 2'b10, in route_i[1:0]), clk_sel_o is 2'b01 (PLL A), whatever the value of spdif_active_i.
- R4: In the case of R3, pwr_dn_o is 1 for every secondary channel (bits 1 and up) and 0 for channel 1 (bit 0).
- R5: With ovr_en_i = 1, spdif_active_i = 0 and ovr_sel_i equal to 2'b00, 2'b01 or 2'b10, clk_sel_o equals ovr_sel_i and both error flags are 0.
- R6: With ovr_en_i = 1 and ovr_sel_i = 2'b11 (reserved), clk_sel_o is 2'b00 and sel_reserved_o is 1.
- R7: With ovr_en_i = 1, spdif_active_i = 1 and ovr_sel_i equal to 2'b01 or 2'b10, clk_sel_o is 2'b00 and sel_invalid_o is 1.
- R8: With ovr_en_i = 1, pwr_dn_o is all zero for any routing.
- R9: Every output takes its new value at the first rising edge after an input change, and not before that edge.
- R10: The routing of DAC channels 2 and above (route_i bits 2 and up) has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Synchronous active-low reset |
| route_i | input | 2*NUM_DAC | Per-channel routing code; channel k in bits [2k+1:2k]; 00 parallel, 01 serial, 10 S/PDIF, 11 as parallel |
| ovr_en_i | input | 1 | Manual override enable |
| ovr_sel_i | input | 2 | Manual select: 00 master, 01 PLL A, 10 PLL B, 11 reserved |
| spdif_active_i | input | 1 | S/PDIF receiver is in use |
| clk_sel_o | output | 2 | Registered clock-select code |
| pwr_dn_o | output | NUM_DAC | Registered per-channel power-down flags, bit 0 is channel 1 |
| sel_invalid_o | output | 1 | Manual PLL choice made while the S/PDIF receiver is in use |
| sel_reserved_o | output | 1 | Manual reserved code requested |

## Verification
Two decisions can fall in the same cycle. One is the fallback to the master clock for a manual PLL choice made while the S/PDIF receiver is in use. The other is the cancelling of the automatic power-down, which the S/PDIF routing of channel 1 would otherwise cause. The bench sets up this case by routing channel 1 to S/PDIF, raising spdif_active_i and enabling the override with PLL A or PLL B, all in one input change. One edge later it expects select 2'b00, the invalid flag set and every power-down flag clear. A vector with the same routing and override, but with the receiver idle, shows that the power-down flags stay clear while the PLL choice goes through.

// File: rtl/dacclk_pkg.sv
// Package: shared encodings for the DAC clock source autoconfiguration.
// Assumes a 2-bit routing code per DAC channel and a 2-bit clock select.
package dacclk_pkg;

    localparam int ROUTE_W = 2;
    localparam int SEL_W   = 2;

    // Clock source codes driven to the downstream clock multiplexer.
    typedef enum logic [SEL_W-1:0] {
        CLK_MASTER = 2'b00,
        CLK_PLLA   = 2'b01,
        CLK_PLLB   = 2'b10,
        CLK_RSVD   = 2'b11
    } clk_src_e;

    // Data source for one DAC channel.
    typedef enum logic [ROUTE_W-1:0] {
        RT_PARALLEL = 2'b00,
        RT_SERIAL   = 2'b01,
        RT_SPDIF    = 2'b10,
        RT_ALT_PAR  = 2'b11
    } route_e;

endpackage

// File: rtl/dacclk_route_decode.sv
// Module: decodes the per-channel routing bus into the single fact the
// clock policy depends on: channel 1 takes its data from the S/PDIF receiver.
// Assumes channel 1 occupies the lowest routing field. The other fields are
// accepted so the bus is whole, but they do not change the decision.
module dacclk_route_decode
    import dacclk_pkg::*;
#(
    parameter int NUM_DAC = 3
) (
    input  logic [NUM_DAC*ROUTE_W-1:0] route_i,
    output logic                       primary_spdif_o
);

    localparam int BUS_W = NUM_DAC * ROUTE_W;

    route_e primary_route;

    // Pick out the channel 1 routing field.
    always_comb begin
        primary_route = route_e'(route_i[ROUTE_W-1:0]);
    end

    // Flag S/PDIF routing of channel 1; code 11 is handled as parallel.
    always_comb begin
        primary_spdif_o = (primary_route == RT_SPDIF);
    end

    // The secondary routing fields do not enter the clock decision.
    logic unused_secondary_routes;
    generate
        if (NUM_DAC > 1) begin : g_sec
            assign unused_secondary_routes = ^route_i[BUS_W-1:ROUTE_W];
        end else begin : g_nosec
            assign unused_secondary_routes = 1'b0;
        end
    endgenerate

endmodule

// File: rtl/dacclk_src_arbiter.sv
// Module: chooses between the routing-driven clock and the manual select,
// and raises the reserved-code and unavailable-PLL flags.
// Assumes both PLL clocks are unavailable while the S/PDIF receiver runs;
// any rejected manual choice falls back to the master clock.
module dacclk_src_arbiter
    import dacclk_pkg::*;
(
    input  logic             primary_spdif_i,
    input  logic             ovr_en_i,
    input  logic [SEL_W-1:0] ovr_sel_i,
    input  logic             spdif_active_i,
    output clk_src_e         sel_next_o,
    output logic             invalid_next_o,
    output logic             reserved_next_o
);

    clk_src_e auto_sel;
    clk_src_e manual_sel;
    logic     manual_is_pll;

    // Routing policy: S/PDIF on channel 1 needs PLL A, otherwise master clock.
    always_comb begin
        auto_sel = primary_spdif_i ? CLK_PLLA : CLK_MASTER;
    end

    // Classify the manual request.
    always_comb begin
        manual_sel    = clk_src_e'(ovr_sel_i);
        manual_is_pll = (manual_sel == CLK_PLLA) || (manual_sel == CLK_PLLB);
    end

    // Final select and error flags; rejected requests fall back to master.
    always_comb begin
        sel_next_o      = auto_sel;
        invalid_next_o  = 1'b0;
        reserved_next_o = 1'b0;
        if (ovr_en_i) begin
            if (manual_sel == CLK_RSVD) begin
                sel_next_o      = CLK_MASTER;
                reserved_next_o = 1'b1;
            end else if (manual_is_pll && spdif_active_i) begin
                sel_next_o     = CLK_MASTER;
                invalid_next_o = 1'b1;
            end else begin
                sel_next_o = manual_sel;
            end
        end
    end

    // R6/R7: a rejected manual request never reaches the multiplexer.
    always_comb begin
        a_r7_reject_is_master: assert (!(invalid_next_o || reserved_next_o)
                                       || sel_next_o == CLK_MASTER);
    end

endmodule

// File: rtl/dacclk_pwr_default.sv
// Module: default power-down flags for each DAC channel.
// Assumes channel 1 is never powered down by this block. The secondary
// channels go down only under S/PDIF routing of channel 1 with no override.
module dacclk_pwr_default #(
    parameter int NUM_DAC = 3
) (
    input  logic               primary_spdif_i,
    input  logic               ovr_en_i,
    output logic [NUM_DAC-1:0] pwr_dn_next_o
);

    // One flag per channel; channel 1 is always kept up.
    genvar ch;
    generate
        for (ch = 0; ch < NUM_DAC; ch++) begin : g_ch
            if (ch == 0) begin : g_primary
                assign pwr_dn_next_o[ch] = 1'b0;
            end else begin : g_secondary
                assign pwr_dn_next_o[ch] = primary_spdif_i & ~ovr_en_i;
            end
        end
    endgenerate

endmodule

// File: rtl/dac_clksrc_autocfg.sv
// Module: top of the DAC clock source autoconfiguration. Decodes the routing,
// arbitrates automatic against manual selection, and registers the select
// code, power-down flags and error flags. Outputs follow the inputs by one clock.
// Assumes all inputs are synchronous to clk; reset is synchronous, active low.
module dac_clksrc_autocfg
    import dacclk_pkg::*;
#(
    parameter int NUM_DAC = 3
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [NUM_DAC*ROUTE_W-1:0] route_i,
    input  logic                       ovr_en_i,
    input  logic [SEL_W-1:0]           ovr_sel_i,
    input  logic                       spdif_active_i,
    output logic [SEL_W-1:0]           clk_sel_o,
    output logic [NUM_DAC-1:0]         pwr_dn_o,
    output logic                       sel_invalid_o,
    output logic                       sel_reserved_o
);

    logic               primary_spdif;
    clk_src_e           sel_next;
    logic               invalid_next;
    logic               reserved_next;
    logic [NUM_DAC-1:0] pwr_dn_next;

    dacclk_route_decode #(.NUM_DAC(NUM_DAC)) u_decode (
        .route_i         (route_i),
        .primary_spdif_o (primary_spdif)
    );

    dacclk_src_arbiter u_arb (
        .primary_spdif_i (primary_spdif),
        .ovr_en_i        (ovr_en_i),
        .ovr_sel_i       (ovr_sel_i),
        .spdif_active_i  (spdif_active_i),
        .sel_next_o      (sel_next),
        .invalid_next_o  (invalid_next),
        .reserved_next_o (reserved_next)
    );

    dacclk_pwr_default #(.NUM_DAC(NUM_DAC)) u_pwr (
        .primary_spdif_i (primary_spdif),
        .ovr_en_i        (ovr_en_i),
        .pwr_dn_next_o   (pwr_dn_next)
    );

    // Output register: reset to master clock, all channels up, no flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_sel_o      <= CLK_MASTER;
            pwr_dn_o       <= '0;
            sel_invalid_o  <= 1'b0;
            sel_reserved_o <= 1'b0;
        end else begin
            clk_sel_o      <= sel_next;
            pwr_dn_o       <= pwr_dn_next;
            sel_invalid_o  <= invalid_next;
            sel_reserved_o <= reserved_next;
        end
    end

    // R1: reset puts every output in its idle state.
    a_r1_reset_idle: assert property (@(posedge clk)
        !rst_n |=> (clk_sel_o == 2'b00 && pwr_dn_o == '0
                    && !sel_invalid_o && !sel_reserved_o));

    // R3: S/PDIF routing of channel 1 without override selects PLL A.
    a_r3_auto_plla: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovr_en_i && route_i[1:0] == 2'b10) |=> clk_sel_o == 2'b01);

    // R4: channel 1 is never powered down.
    a_r4_primary_up: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> !pwr_dn_o[0]);

    // R6: reserved manual code lands on the master clock with its flag.
    a_r6_reserved: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en_i && ovr_sel_i == 2'b11) |=> (clk_sel_o == 2'b00 && sel_reserved_o));

    // R7: manual PLL while the receiver runs is flagged and rejected.
    a_r7_pll_unavailable: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr_en_i && spdif_active_i && (ovr_sel_i == 2'b01 || ovr_sel_i == 2'b10))
        |=> (clk_sel_o == 2'b00 && sel_invalid_o));

    // R8: override keeps every channel powered.
    a_r8_override_no_pd: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_en_i |=> pwr_dn_o == '0);

    // R9: outputs hold when inputs held stable across two edges.
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ($stable(route_i) && $stable(ovr_en_i) && $stable(ovr_sel_i)
         && $stable(spdif_active_i) && $past(rst_n)) |=> $stable(clk_sel_o));

    // R6/R7: the two error flags never coexist.
    a_r7_flags_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(sel_invalid_o && sel_reserved_o));

endmodule

// File: tb/test_dac_clksrc_autocfg.sv
// Bench: vector table walked by one loop, then directed reset, latency tests.
module test_dac_clksrc_autocfg;

    localparam int NUM_DAC = 3;
    // Vector: req[3:0] route[5:0] ovr sel[1:0] spdif | exp_sel[1:0] exp_pd[2:0] inv res
    localparam int VW = 21;
    localparam int NV = 15;
    localparam logic [VW-1:0] VEC [NV] = '{
        {4'd2,  6'b000000, 1'b0, 2'b00, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0}, // R2 parallel
        {4'd2,  6'b000001, 1'b0, 2'b00, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0}, // R2 serial
        {4'd3,  6'b000010, 1'b0, 2'b00, 1'b1, 2'b01, 3'b110, 1'b0, 1'b0}, // R3 active
        {4'd4,  6'b000010, 1'b0, 2'b10, 1'b0, 2'b01, 3'b110, 1'b0, 1'b0}, // R4 idle rx
        {4'd2,  6'b000011, 1'b0, 2'b00, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0}, // R2 code 11
        {4'd10, 6'b101000, 1'b0, 2'b00, 1'b0, 2'b00, 3'b000, 1'b0, 1'b0}, // R10
        {4'd10, 6'b010110, 1'b0, 2'b00, 1'b0, 2'b01, 3'b110, 1'b0, 1'b0}, // R10
        {4'd5,  6'b000000, 1'b1, 2'b01, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0}, // R5 PLL A
        {4'd5,  6'b000000, 1'b1, 2'b10, 1'b0, 2'b10, 3'b000, 1'b0, 1'b0}, // R5 PLL B
        {4'd5,  6'b000001, 1'b1, 2'b00, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0}, // R5 master
        {4'd8,  6'b000010, 1'b1, 2'b00, 1'b1, 2'b00, 3'b000, 1'b0, 1'b0}, // R8
        {4'd6,  6'b000010, 1'b1, 2'b11, 1'b0, 2'b00, 3'b000, 1'b0, 1'b1}, // R6
        {4'd7,  6'b000010, 1'b1, 2'b10, 1'b1, 2'b00, 3'b000, 1'b1, 1'b0}, // R7 + R8
        {4'd7,  6'b000000, 1'b1, 2'b01, 1'b1, 2'b00, 3'b000, 1'b1, 1'b0}, // R7
        {4'd8,  6'b000010, 1'b1, 2'b01, 1'b0, 2'b01, 3'b000, 1'b0, 1'b0}  // R8
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [NUM_DAC*2-1:0] route_i = '0;
    logic                 ovr_en_i = 1'b0;
    logic [1:0]           ovr_sel_i = 2'b00;
    logic                 spdif_active_i = 1'b0;
    logic [1:0]           clk_sel_o;
    logic [NUM_DAC-1:0]   pwr_dn_o;
    logic                 sel_invalid_o;
    logic                 sel_reserved_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk; // 125 MHz

    dac_clksrc_autocfg #(.NUM_DAC(NUM_DAC)) i_dac_clksrc_autocfg (
        .clk            (clk),
        .rst_n          (rst_n),
        .route_i        (route_i),
        .ovr_en_i       (ovr_en_i),
        .ovr_sel_i      (ovr_sel_i),
        .spdif_active_i (spdif_active_i),
        .clk_sel_o      (clk_sel_o),
        .pwr_dn_o       (pwr_dn_o),
        .sel_invalid_o  (sel_invalid_o),
        .sel_reserved_o (sel_reserved_o)
    );

    task automatic check_out(input string req, input logic [1:0] esel,
                             input logic [2:0] epd, input logic einv, input logic eres);
        checks++;
        if (clk_sel_o !== esel || pwr_dn_o !== epd ||
            sel_invalid_o !== einv || sel_reserved_o !== eres) begin
            errors++;
            $display("FAIL %s: got sel=%b pd=%b inv=%b res=%b, expected sel=%b pd=%b inv=%b res=%b",
                     req, clk_sel_o, pwr_dn_o, sel_invalid_o, sel_reserved_o,
                     esel, epd, einv, eres);
        end
    endtask

    task automatic drive(input logic [5:0] rt, input logic ov, input logic [1:0] sl,
                         input logic sp);
        route_i = rt; ovr_en_i = ov; ovr_sel_i = sl; spdif_active_i = sp;
    endtask

    initial begin
        #200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1: reset with a configuration that would otherwise drive PLL A.
        drive(6'b000010, 1'b0, 2'b00, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_out("R1 reset", 2'b00, 3'b000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);

        // Vector table walk (R2..R8, R10).
        for (int v = 0; v < NV; v++) begin
            logic [VW-1:0] w;
            w = VEC[v];
            drive(w[16:11], w[10], w[9:8], w[7]);
            @(posedge clk);
            @(negedge clk);
            check_out($sformatf("R%0d vec%0d", w[20:17], v), w[6:5], w[4:2], w[1], w[0]);
        end

        // R9: output holds until the edge, then changes.
        drive(6'b000000, 1'b0, 2'b00, 1'b0);
        @(posedge clk);
        @(negedge clk);
        drive(6'b000010, 1'b0, 2'b00, 1'b0);
        #1;
        check_out("R9 before edge", 2'b00, 3'b000, 1'b0, 1'b0);
        @(posedge clk);
        #1;
        check_out("R9 after edge", 2'b01, 3'b110, 1'b0, 1'b0);

        // R10: only secondary routing changes; outputs stay as set by channel 1.
        @(negedge clk);
        drive(6'b101010, 1'b0, 2'b00, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_out("R10 secondary spdif", 2'b01, 3'b110, 1'b0, 1'b0);

        // R1: reset in mid-run clears error flag state.
        drive(6'b000000, 1'b1, 2'b11, 1'b0);
        @(posedge clk);
        @(negedge clk);
        check_out("R6 before reset", 2'b00, 3'b000, 1'b0, 1'b1);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check_out("R1 mid-run reset", 2'b00, 3'b000, 1'b0, 1'b0);
        rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule